// File: doc/BRIEF.md
# Two-Way Data Cache with Line Hint Commands

This block is a small two-way set-associative write-back data cache. A core-side port accepts one command at a time as an opcode plus a byte address, with write data for stores. Besides ordinary loads and stores, the command set includes per-line management hints. Prefetch pulls a line in without returning data. Zero-allocate installs a zeroed line without reading memory. Discard drops a line without writing it back, even if it is dirty. Evict writes a dirty line back and frees its way. Read-once returns a word and leaves the line as the next replacement candidate in its set.

Each set holds two ways and a single bit that names the way to replace next. Misses pick an empty way first, otherwise the named way. A dirty victim is written to memory before the new line is brought in. The memory side moves whole lines, one request at a time, and holds each request until the memory acknowledges it.

Command codes on `cmd_op`: 0 load, 1 store, 2 prefetch, 3 zero-allocate, 4 discard, 5 evict, 6 read-once. Code 7 completes without any effect.

Top module: `dcache_hint`

## Requirements
- R1: A load (code 0) returns the addressed 32-bit word. A miss fetches the whole line from memory once, and a repeat load of that line causes no memory traffic.
- R2: A store (code 1) writes the word into the cache, allocating the line on a miss. The line becomes dirty, and later loads return the stored value without memory traffic.
- R3: A prefetch (code 2) brings an absent line in with exactly one line read and completes with `rsp_data` equal to zero. A prefetch that hits causes no memory traffic.
- R4: A zero-allocate (code 3) makes every word of the aligned line read as zero, ignores the address bits below the 16-byte line size, and issues no memory read. The line is dirty, so a later evict writes zeros to memory.
- R5: A discard (code 4) invalidates the line with no memory write, even when the line is dirty. A following load returns the value held in memory.
- R6: An evict (code 5) of a dirty line writes the line to memory once and invalidates it. An evict of an absent line completes with no memory traffic.
- R7: A read-once (code 6) returns the word like a load and keeps the line resident, but makes it the next victim of its set.
- R8: A miss fills an invalid way when one exists, otherwise the least recently used way. Loads, stores, prefetches and zero-allocates make the touched way most recently used. A dirty victim is written back before the new line is installed.
- R9: `cmd_ready` drops in the cycle after a command is accepted and stays low until completion. Completion is a one-cycle `rsp_valid` pulse. A memory request holds its address and direction until `mem_ack`.
- R10: After reset, `cmd_ready` is high, `rsp_valid` and `mem_req` are low, and every line is invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Cache idle and able to take a command |
| cmd_op | input | 3 | Command code |
| cmd_addr | input | ADDR_W | Byte address |
| cmd_wdata | input | WORD_W | Store data |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_data | output | WORD_W | Load data, zero for other commands |
| mem_req | output | 1 | Line transfer request |
| mem_we | output | 1 | 1 = write line to memory, 0 = read line |
| mem_addr | output | ADDR_W | Line-aligned byte address |
| mem_wdata | output | LINE_W | Line written to memory |
| mem_ack | input | 1 | Memory completes the transfer |
| mem_rdata | input | LINE_W | Line read from memory |

## Verification
The completion pulse of one command and the acceptance of the next can fall in the same cycle, because `cmd_ready` rises together with `rsp_valid`. The bench provokes this on every command by presenting the next command at once in the response cycle. It judges the result by comparing each returned word against a reference memory image kept by bench functions. Within a single miss, a dirty writeback and the following fill fall in back-to-back transfers. The bench forces this with set conflicts and judges it from the memory image after every line has been evicted.

// File: rtl/dcache_hint.sv
module dcache_hint #(
  parameter int ADDR_W     = 12,
  parameter int WORD_W     = 32,
  parameter int LINE_WORDS = 4,
  parameter int SETS       = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         cmd_valid,
  output logic                         cmd_ready,
  input  logic [2:0]                   cmd_op,
  input  logic [ADDR_W-1:0]            cmd_addr,
  input  logic [WORD_W-1:0]            cmd_wdata,
  output logic                         rsp_valid,
  output logic [WORD_W-1:0]            rsp_data,
  output logic                         mem_req,
  output logic                         mem_we,
  output logic [ADDR_W-1:0]            mem_addr,
  output logic [WORD_W*LINE_WORDS-1:0] mem_wdata,
  input  logic                         mem_ack,
  input  logic [WORD_W*LINE_WORDS-1:0] mem_rdata
);
  localparam int BYTE_OFF = $clog2(WORD_W / 8);
  localparam int WORD_OFF = $clog2(LINE_WORDS);
  localparam int OFF_W    = BYTE_OFF + WORD_OFF;
  localparam int IDX_W    = $clog2(SETS);
  localparam int TAG_W    = ADDR_W - OFF_W - IDX_W;
  localparam int LINE_W   = WORD_W * LINE_WORDS;

  localparam logic [2:0] OP_LOAD  = 3'd0;
  localparam logic [2:0] OP_STORE = 3'd1;
  localparam logic [2:0] OP_PREF  = 3'd2;
  localparam logic [2:0] OP_ZERO  = 3'd3;
  localparam logic [2:0] OP_DROP  = 3'd4;
  localparam logic [2:0] OP_EVICT = 3'd5;
  localparam logic [2:0] OP_ONCE  = 3'd6;

  typedef enum logic [1:0] {S_IDLE, S_LOOK, S_WB, S_FILL} state_t;

  state_t                state_q;
  logic [2:0]            op_q;
  logic [ADDR_W-1:0]     addr_q;
  logic [WORD_W-1:0]     wdata_q;
  logic                  way_q;
  logic                  we_q;
  logic [ADDR_W-1:0]     maddr_q;

  logic [TAG_W-1:0]      tag_q   [2][SETS];
  logic [LINE_W-1:0]     data_q  [2][SETS];
  logic                  valid_q [2][SETS];
  logic                  dirty_q [2][SETS];
  logic                  lru_q   [SETS];

  logic [IDX_W-1:0]      idx;
  logic [TAG_W-1:0]      tg;
  logic [WORD_OFF-1:0]   wsel;
  logic                  hit0, hit1, hit, hway;
  logic                  vway, vict_dirty;
  logic [LINE_W-1:0]     hit_line, st_line;
  logic [WORD_W-1:0]     hit_word;

  logic                  wr_en, wr_way;
  logic [LINE_W-1:0]     wr_line;

  assign idx  = addr_q[OFF_W +: IDX_W];
  assign tg   = addr_q[ADDR_W-1 -: TAG_W];
  assign wsel = addr_q[BYTE_OFF +: WORD_OFF];

  assign hit0 = valid_q[0][idx] && (tag_q[0][idx] == tg);
  assign hit1 = valid_q[1][idx] && (tag_q[1][idx] == tg);
  assign hit  = hit0 || hit1;
  assign hway = hit1;

  assign vway       = !valid_q[0][idx] ? 1'b0 : (!valid_q[1][idx] ? 1'b1 : lru_q[idx]);
  assign vict_dirty = valid_q[vway][idx] && dirty_q[vway][idx];

  assign hit_line = data_q[hway][idx];
  assign hit_word = hit_line[wsel*WORD_W +: WORD_W];

  always_comb begin
    st_line = hit_line;
    st_line[wsel*WORD_W +: WORD_W] = wdata_q;
  end

  assign cmd_ready = (state_q == S_IDLE);
  assign mem_req   = (state_q == S_WB) || (state_q == S_FILL);
  assign mem_we    = we_q;
  assign mem_addr  = maddr_q;
  assign mem_wdata = data_q[way_q][idx];

  always_comb begin
    wr_en   = 1'b0;
    wr_way  = hway;
    wr_line = st_line;
    case (state_q)
      S_LOOK: begin
        if (hit && op_q == OP_STORE) begin
          wr_en = 1'b1;
        end else if (hit && op_q == OP_ZERO) begin
          wr_en   = 1'b1;
          wr_line = '0;
        end else if (!hit && op_q == OP_ZERO && !vict_dirty) begin
          wr_en   = 1'b1;
          wr_way  = vway;
          wr_line = '0;
        end
      end
      S_FILL: begin
        if (mem_ack) begin
          wr_en   = 1'b1;
          wr_way  = way_q;
          wr_line = mem_rdata;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      data_q[wr_way][idx] <= wr_line;
      tag_q[wr_way][idx]  <= tg;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= S_IDLE;
      op_q      <= OP_LOAD;
      addr_q    <= '0;
      wdata_q   <= '0;
      way_q     <= 1'b0;
      we_q      <= 1'b0;
      maddr_q   <= '0;
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
      for (int s = 0; s < SETS; s++) begin
        valid_q[0][s] <= 1'b0;
        valid_q[1][s] <= 1'b0;
        dirty_q[0][s] <= 1'b0;
        dirty_q[1][s] <= 1'b0;
        lru_q[s]      <= 1'b0;
      end
    end else begin
      rsp_valid <= 1'b0;
      case (state_q)
        S_IDLE: begin
          if (cmd_valid) begin
            op_q    <= cmd_op;
            addr_q  <= cmd_addr;
            wdata_q <= cmd_wdata;
            state_q <= S_LOOK;
          end
        end
        S_LOOK: begin
          case (op_q)
            OP_LOAD, OP_STORE, OP_PREF, OP_ONCE: begin
              if (hit) begin
                lru_q[idx] <= (op_q == OP_ONCE) ? hway : ~hway;
                if (op_q == OP_STORE) dirty_q[hway][idx] <= 1'b1;
                rsp_data  <= (op_q == OP_LOAD || op_q == OP_ONCE) ? hit_word : '0;
                rsp_valid <= 1'b1;
                state_q   <= S_IDLE;
              end else begin
                way_q <= vway;
                if (vict_dirty) begin
                  we_q    <= 1'b1;
                  maddr_q <= {tag_q[vway][idx], idx, {OFF_W{1'b0}}};
                  state_q <= S_WB;
                end else begin
                  we_q    <= 1'b0;
                  maddr_q <= {tg, idx, {OFF_W{1'b0}}};
                  state_q <= S_FILL;
                end
              end
            end
            OP_ZERO: begin
              if (hit) begin
                dirty_q[hway][idx] <= 1'b1;
                lru_q[idx]         <= ~hway;
                rsp_data           <= '0;
                rsp_valid          <= 1'b1;
                state_q            <= S_IDLE;
              end else if (vict_dirty) begin
                way_q   <= vway;
                we_q    <= 1'b1;
                maddr_q <= {tag_q[vway][idx], idx, {OFF_W{1'b0}}};
                state_q <= S_WB;
              end else begin
                valid_q[vway][idx] <= 1'b1;
                dirty_q[vway][idx] <= 1'b1;
                lru_q[idx]         <= ~vway;
                rsp_data           <= '0;
                rsp_valid          <= 1'b1;
                state_q            <= S_IDLE;
              end
            end
            OP_DROP: begin
              if (hit) begin
                valid_q[hway][idx] <= 1'b0;
                dirty_q[hway][idx] <= 1'b0;
              end
              rsp_data  <= '0;
              rsp_valid <= 1'b1;
              state_q   <= S_IDLE;
            end
            OP_EVICT: begin
              if (hit && dirty_q[hway][idx]) begin
                way_q   <= hway;
                we_q    <= 1'b1;
                maddr_q <= {tg, idx, {OFF_W{1'b0}}};
                state_q <= S_WB;
              end else begin
                if (hit) valid_q[hway][idx] <= 1'b0;
                rsp_data  <= '0;
                rsp_valid <= 1'b1;
                state_q   <= S_IDLE;
              end
            end
            default: begin
              rsp_data  <= '0;
              rsp_valid <= 1'b1;
              state_q   <= S_IDLE;
            end
          endcase
        end
        S_WB: begin
          if (mem_ack) begin
            valid_q[way_q][idx] <= 1'b0;
            dirty_q[way_q][idx] <= 1'b0;
            state_q             <= S_LOOK;
          end
        end
        S_FILL: begin
          if (mem_ack) begin
            valid_q[way_q][idx] <= 1'b1;
            dirty_q[way_q][idx] <= 1'b0;
            state_q             <= S_LOOK;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  // R9
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we));

  // R9
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  // R9
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_ready |=> !cmd_ready);

  // R9
  no_req_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !cmd_ready);

  // R5
  drop_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we |-> op_q != OP_DROP);

  // R4
  zero_no_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_we |-> op_q != OP_ZERO);

  // R3
  pref_no_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && op_q == OP_PREF |-> rsp_data == '0);
endmodule

// File: tb/test_dcache_hint.sv
module test_dcache_hint;
  localparam int AW = 12;
  localparam int WW = 32;
  localparam int LW = 128;
  localparam int NWORDS = 1024;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmd_valid = 1'b0;
  logic          cmd_ready;
  logic [2:0]    cmd_op = '0;
  logic [AW-1:0] cmd_addr = '0;
  logic [WW-1:0] cmd_wdata = '0;
  logic          rsp_valid;
  logic [WW-1:0] rsp_data;
  logic          mem_req, mem_we;
  logic [AW-1:0] mem_addr;
  logic [LW-1:0] mem_wdata;
  logic          mem_ack = 1'b0;
  logic [LW-1:0] mem_rdata = '0;

  dcache_hint i_dcache_hint (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  always #5 clk = ~clk;

  logic [WW-1:0] bmem [NWORDS];
  logic [WW-1:0] arch [NWORDS];
  int total = 0, bad = 0, rd_cnt = 0, wr_cnt = 0, hs_bad = 0, cycles = 0;

  function automatic logic [WW-1:0] pat(input int i);
    return 32'h5A00_0000 + i * 32'h0001_0203;
  endfunction

  task automatic chk(input string req, input logic [WW-1:0] act, input logic [WW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        total++;
        bad++;
        $display("FAIL watchdog actual=%0d expected=<150000", cycles);
        finish_run();
      end
    end
  end

  initial begin
    forever begin
      @(negedge clk);
      if (mem_req && !mem_ack) begin
        repeat (2) @(negedge clk);
        if (mem_we) begin
          for (int i = 0; i < 4; i++) bmem[(int'(mem_addr) >> 2) + i] = mem_wdata[i*WW +: WW];
          wr_cnt++;
        end else begin
          for (int i = 0; i < 4; i++) mem_rdata[i*WW +: WW] = bmem[(int'(mem_addr) >> 2) + i];
          rd_cnt++;
        end
        mem_ack = 1'b1;
        @(negedge clk);
        mem_ack = 1'b0;
      end
    end
  end

  task automatic do_cmd(input logic [2:0] op, input int addr, input logic [WW-1:0] wd,
                        output logic [WW-1:0] rd);
    while (!cmd_ready) @(negedge clk);
    cmd_valid = 1'b1;
    cmd_op    = op;
    cmd_addr  = addr[AW-1:0];
    cmd_wdata = wd;
    @(negedge clk);
    cmd_valid = 1'b0;
    while (!rsp_valid) begin
      if (cmd_ready) hs_bad++;
      @(negedge clk);
    end
    rd = rsp_data;
  endtask

  task automatic zero_line(input int addr);
    for (int i = 0; i < 4; i++) arch[((addr >> 4) << 2) + i] = '0;
  endtask

  int r0, w0;
  logic [WW-1:0] d;

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < NWORDS; i++) begin
      bmem[i] = pat(i);
      arch[i] = pat(i);
    end
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10 ready", {31'd0, cmd_ready}, 32'd1);
    chk("R10 rsp_valid", {31'd0, rsp_valid}, 32'd0);
    chk("R10 mem_req", {31'd0, mem_req}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 load miss then hit
    r0 = rd_cnt;
    do_cmd(3'd0, 24, '0, d);
    chk("R1 miss data", d, arch[6]);
    chk("R1 miss reads", rd_cnt - r0, 1);
    r0 = rd_cnt;
    do_cmd(3'd0, 24, '0, d);
    chk("R1 hit reads", rd_cnt - r0, 0);
    chk("R10 first access saw invalid cache", d, arch[6]);

    // R2 store hit and store miss with allocation
    r0 = rd_cnt;
    do_cmd(3'd1, 24, 32'hCAFE_0001, d); arch[6] = 32'hCAFE_0001;
    do_cmd(3'd0, 24, '0, d);
    chk("R2 store hit data", d, 32'hCAFE_0001);
    chk("R2 store hit reads", rd_cnt - r0, 0);
    r0 = rd_cnt;
    do_cmd(3'd1, 36, 32'hBEEF_0002, d); arch[9] = 32'hBEEF_0002;
    chk("R2 allocate reads", rd_cnt - r0, 1);
    do_cmd(3'd0, 36, '0, d);
    chk("R2 allocated data", d, 32'hBEEF_0002);
    do_cmd(3'd0, 32, '0, d);
    chk("R2 neighbour word", d, arch[8]);

    // R3 prefetch
    r0 = rd_cnt; w0 = wr_cnt;
    do_cmd(3'd2, 48, '0, d);
    chk("R3 prefetch data zero", d, 32'd0);
    chk("R3 prefetch reads", rd_cnt - r0, 1);
    r0 = rd_cnt;
    do_cmd(3'd0, 52, '0, d);
    chk("R3 after prefetch data", d, arch[13]);
    chk("R3 after prefetch reads", rd_cnt - r0, 0);
    do_cmd(3'd2, 56, '0, d);
    chk("R3 prefetch hit traffic", (rd_cnt - r0) + (wr_cnt - w0), 0);

    // R4 zero-allocate with unaligned address
    r0 = rd_cnt; w0 = wr_cnt;
    do_cmd(3'd3, 64 + 6, '0, d); zero_line(64);
    chk("R4 no reads", rd_cnt - r0, 0);
    for (int i = 0; i < 4; i++) begin
      do_cmd(3'd0, 64 + i*4, '0, d);
      chk("R4 zero word", d, 32'd0);
    end
    chk("R4 no traffic", (rd_cnt - r0) + (wr_cnt - w0), 0);
    do_cmd(3'd5, 64, '0, d);
    chk("R4 zeros written", wr_cnt - w0, 1);
    chk("R4 memory zero", bmem[16] | bmem[17] | bmem[18] | bmem[19], 32'd0);

    // R5 discard of dirty line
    do_cmd(3'd1, 80, 32'h1234_5678, d);
    w0 = wr_cnt; r0 = rd_cnt;
    do_cmd(3'd4, 80, '0, d); arch[20] = bmem[20];
    chk("R5 no write", wr_cnt - w0, 0);
    do_cmd(3'd0, 80, '0, d);
    chk("R5 old value", d, pat(20));
    chk("R5 refetch", rd_cnt - r0, 1);

    // R6 evict dirty line, then evict absent line
    do_cmd(3'd1, 96, 32'h0BAD_F00D, d); arch[24] = 32'h0BAD_F00D;
    w0 = wr_cnt;
    do_cmd(3'd5, 96, '0, d);
    chk("R6 one write", wr_cnt - w0, 1);
    chk("R6 memory value", bmem[24], 32'h0BAD_F00D);
    w0 = wr_cnt; r0 = rd_cnt;
    do_cmd(3'd5, 96, '0, d);
    chk("R6 miss no traffic", (rd_cnt - r0) + (wr_cnt - w0), 0);
    do_cmd(3'd4, 160, '0, d);
    chk("R5 discard miss no traffic", (rd_cnt - r0) + (wr_cnt - w0), 0);
    do_cmd(3'd0, 96, '0, d);
    chk("R6 line was freed", rd_cnt - r0, 1);

    // R7 read-once in set 7 (lines A=112, B=240, C=368)
    do_cmd(3'd0, 112, '0, d);
    do_cmd(3'd0, 240, '0, d);
    r0 = rd_cnt;
    do_cmd(3'd6, 244, '0, d);
    chk("R7 data", d, arch[61]);
    chk("R7 resident", rd_cnt - r0, 0);
    do_cmd(3'd0, 368, '0, d);
    r0 = rd_cnt;
    do_cmd(3'd0, 112, '0, d);
    chk("R7 A kept", rd_cnt - r0, 0);
    do_cmd(3'd0, 240, '0, d);
    chk("R7 B was victim", rd_cnt - r0, 1);

    // R8 invalid way preferred over LRU way
    w0 = wr_cnt;
    do_cmd(3'd5, 240, '0, d);
    chk("R6 clean evict no write", wr_cnt - w0, 0);
    do_cmd(3'd0, 368, '0, d);
    r0 = rd_cnt;
    do_cmd(3'd0, 112, '0, d);
    chk("R8 invalid way used", rd_cnt - r0, 0);

    // R8 dirty victim written back before fill
    do_cmd(3'd1, 112, 32'hD1D1_D1D1, d); arch[28] = 32'hD1D1_D1D1;
    w0 = wr_cnt;
    do_cmd(3'd0, 240, '0, d);
    chk("R8 clean victim no write", wr_cnt - w0, 0);
    do_cmd(3'd0, 368, '0, d);
    chk("R8 dirty victim write", wr_cnt - w0, 1);
    chk("R8 victim data in memory", bmem[28], 32'hD1D1_D1D1);
    chk("R8 fill data", d, arch[92]);
    do_cmd(3'd0, 112, '0, d);
    r0 = rd_cnt;
    do_cmd(3'd0, 368, '0, d);
    chk("R8 LRU way replaced", rd_cnt - r0, 0);

    // random mix of semantics-preserving commands
    for (int n = 0; n < 800; n++) begin
      int sel, line, wrd, a;
      logic [WW-1:0] v;
      sel  = int'($urandom % 100);
      line = int'($urandom % 40);
      wrd  = int'($urandom % 4);
      a    = line * 16 + wrd * 4;
      v    = $urandom;
      if (sel < 35) begin
        do_cmd(3'd0, a, '0, d);
        chk("R1 random load", d, arch[a >> 2]);
      end else if (sel < 60) begin
        do_cmd(3'd1, a, v, d); arch[a >> 2] = v;
      end else if (sel < 70) begin
        do_cmd(3'd2, a, '0, d);
        chk("R3 random prefetch", d, 32'd0);
      end else if (sel < 75) begin
        do_cmd(3'd3, a + int'($urandom % 4), '0, d); zero_line(a);
      end else if (sel < 85) begin
        do_cmd(3'd5, a, '0, d);
      end else begin
        do_cmd(3'd6, a, '0, d);
        chk("R7 random read-once", d, arch[a >> 2]);
      end
    end

    // evict everything and compare memory image
    for (int l = 0; l < 64; l++) do_cmd(3'd5, l * 16, '0, d);
    for (int l = 0; l < 64; l++) begin
      int mism = 0;
      for (int i = 0; i < 4; i++) if (bmem[l*4+i] !== arch[l*4+i]) mism++;
      chk("R8 memory image line", mism, 0);
    end
    chk("R9 ready low while busy", hs_bad, 0);
    finish_run();
  end
endmodule